// File: doc/BRIEF.md
# Status-Tagged Serial Channel

This block is a full-duplex asynchronous serial channel for 8-bit characters with no parity and one stop bit. Transmit and receive run at the same time. A programmable divisor sets the line rate: the internal generator makes a tick every `div+1` clocks, and one bit lasts 16 ticks. A host writes characters into an 8-entry transmit queue. It reads received characters from a 16-entry receive queue.

Each receive entry is 13 bits wide. It holds the character and a 5-bit tag that records what happened to that character: framing error, overrun, break, parity error (always zero with no parity) and an idle-gap marker. The tag is written together with the character, so errors stay attached to the character they belong to, even when the host reads the queue much later. Two level-sensitive DMA request outputs tell a DMA engine when the transmit queue has room and when the receive queue holds data.

Top module: `uart_tagq`

## Requirements
- R1: After reset `txd_o` is 1, `rx_empty_o` is 1, `tx_full_o` is 0, `tx_dreq_o` is 1 and `rx_dreq_o` is 0.
- R2: A transmitted frame is one low start bit, then 8 data bits with the LSB first, then one high stop bit. Each bit lasts 16*(div+1) clocks, and the line idles high.
- R3: The transmit queue stores 8 characters in addition to the one being shifted out. `tx_full_o` is 1 when the queue is full, and a write made while it is full is discarded.
- R4: A received frame with a high stop bit is stored as `rx_data_o` = the character, and `rx_stat_o` bits 0 to 3 are zero. Tag bit 3 (parity error) is always 0.
- R5: A received frame whose stop bit is sampled low sets tag bit 0 (framing error).
- R6: A received frame with all-zero data and a low stop bit sets tag bit 2 (break) together with bit 0.
- R7: The receive queue holds 16 entries. A character that completes while the queue is full is dropped, and tag bit 1 (overrun) is set on the next character that is stored.
- R8: Tag bit 4 is set when the line stayed high for at least GAP_BITS bit times before the start bit, or when the character is the first one after reset. It is clear for back-to-back frames.
- R9: `tx_dreq_o` is 1 exactly while the transmit queue is not full. `rx_dreq_o` is 1 exactly while the receive queue is not empty.
- R10: Reception and transmission proceed at the same time without corrupting each other.
- R11: Writing a new divisor through `div_we_i` changes the bit time of both directions for later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_we_i | input | 1 | Load the baud divisor |
| div_i | input | DIV_W | Divisor value; tick period is div+1 clocks |
| tx_we_i | input | 1 | Push `tx_data_i` into the transmit queue |
| tx_data_i | input | 8 | Character to transmit |
| tx_full_o | output | 1 | Transmit queue full |
| rx_re_i | input | 1 | Pop the head of the receive queue |
| rx_data_o | output | 8 | Character at the head of the receive queue |
| rx_stat_o | output | 5 | Tag of the head entry: [0] framing, [1] overrun, [2] break, [3] parity, [4] gap |
| rx_empty_o | output | 1 | Receive queue empty |
| tx_dreq_o | output | 1 | Transmit DMA request (room in queue) |
| rx_dreq_o | output | 1 | Receive DMA request (data in queue) |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |

## Verification
A wrong receiver bit counter or sample phase shows up in the head entry of the receive queue as soon as the affected frame's stop bit is sampled: the data byte is shifted, or the tag is wrong. A stuck overrun or gap flag shows on the next stored entry and can hide there for a whole burst. Transmit-side faults show at `txd_o` within one frame, as a bit shifted in time or a byte skipped. Queue pointer faults appear as repeated or missing characters and as wrong full or request levels right after a burst.

// File: rtl/uart_tq_pkg.sv
package uart_tq_pkg;
  localparam int STAT_W = 5;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
  // bit 4..0: gap, parity, break, overrun, framing
  typedef struct packed {
    logic gap;
    logic perr;
    logic brk;
    logic ovr;
    logic ferr;
  } rx_stat_t;
endpackage

// File: rtl/uart_tq_baud.sv
module uart_tq_baud #(
  parameter int DIV_W = 16,
  parameter logic [DIV_W-1:0] DEF_DIV = 53
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             div_we_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q, cnt_q;

  assign tick_o = (cnt_q == div_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= DEF_DIV;
      cnt_q <= '0;
    end else if (div_we_i) begin
      div_q <= div_i;
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/uart_tq_fifo.sv
module uart_tq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign dout_o  = mem[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= wp_q + 1'b1;
      if (pop_ok)  rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
    end
  end
endmodule

// File: rtl/uart_tq_tx.sv
module uart_tq_tx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       avail_i,
  input  logic [7:0] data_i,
  output logic       pop_o,
  output logic       busy_o,
  output logic       txd_o
);
  logic [8:0] sh_q;
  logic [3:0] tcnt_q, bcnt_q;

  assign pop_o = !busy_o && avail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      txd_o  <= 1'b1;
      sh_q   <= '1;
      tcnt_q <= '0;
      bcnt_q <= '0;
    end else if (pop_o) begin
      busy_o <= 1'b1;
      txd_o  <= 1'b0;
      sh_q   <= {1'b1, data_i};
      tcnt_q <= '0;
      bcnt_q <= '0;
    end else if (busy_o && tick_i) begin
      tcnt_q <= tcnt_q + 1'b1;
      if (tcnt_q == 4'd15) begin
        if (bcnt_q == 4'd9) begin
          busy_o <= 1'b0;
        end else begin
          txd_o  <= sh_q[0];
          sh_q   <= {1'b1, sh_q[8:1]};
          bcnt_q <= bcnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_tq_rx.sv
module uart_tq_rx
  import uart_tq_pkg::*;
#(
  parameter int GAP_BITS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  output logic       done_o,
  output logic [7:0] data_o,
  output logic       ferr_o,
  output logic       brk_o,
  output logic       gap_o
);
  localparam int GAP_T = GAP_BITS * 16;
  localparam int GW    = $clog2(GAP_T + 1);

  rx_state_e      st_q;
  logic [3:0]     tcnt_q;
  logic [2:0]     bcnt_q;
  logic           armed_q;
  logic [GW-1:0]  gcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RX_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      armed_q <= 1'b0;
      gcnt_q  <= GW'(GAP_T);
      data_o  <= '0;
      done_o  <= 1'b0;
      ferr_o  <= 1'b0;
      brk_o   <= 1'b0;
      gap_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        unique case (st_q)
          RX_IDLE: begin
            if (rxd_i) begin
              armed_q <= 1'b1;
              if (armed_q && gcnt_q != GW'(GAP_T)) gcnt_q <= gcnt_q + 1'b1;
            end else if (armed_q) begin
              st_q   <= RX_START;
              tcnt_q <= '0;
              gap_o  <= (gcnt_q == GW'(GAP_T));
              gcnt_q <= '0;
            end
          end
          RX_START: begin
            tcnt_q <= tcnt_q + 1'b1;
            if (tcnt_q == 4'd7) begin
              tcnt_q <= '0;
              bcnt_q <= '0;
              st_q   <= rxd_i ? RX_IDLE : RX_DATA; // mid-bit start check
            end
          end
          RX_DATA: begin
            tcnt_q <= tcnt_q + 1'b1;
            if (tcnt_q == 4'd15) begin
              data_o <= {rxd_i, data_o[7:1]};
              bcnt_q <= bcnt_q + 1'b1;
              if (bcnt_q == 3'd7) st_q <= RX_STOP;
            end
          end
          RX_STOP: begin
            tcnt_q <= tcnt_q + 1'b1;
            if (tcnt_q == 4'd15) begin
              done_o  <= 1'b1;
              ferr_o  <= !rxd_i;
              brk_o   <= !rxd_i && (data_o == '0);
              armed_q <= rxd_i;
              gcnt_q  <= '0;
              st_q    <= RX_IDLE;
            end
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_tagq.sv
module uart_tagq
  import uart_tq_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter logic [DIV_W-1:0] DEF_DIV = 53,
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 16,
  parameter int GAP_BITS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             div_we_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             tx_we_i,
  input  logic [7:0]       tx_data_i,
  output logic             tx_full_o,
  input  logic             rx_re_i,
  output logic [7:0]       rx_data_o,
  output logic [4:0]       rx_stat_o,
  output logic             rx_empty_o,
  output logic             tx_dreq_o,
  output logic             rx_dreq_o,
  input  logic             rxd_i,
  output logic             txd_o
);
  localparam int RX_W = 8 + STAT_W;

  logic       tick;
  logic       rxd_s1, rxd_s2;
  logic       tx_empty, tx_pop, tx_busy;
  logic [7:0] tx_head;
  logic       rx_done, rx_ferr, rx_brk, rx_gap, rx_full, ovr_pend;
  logic [7:0] rx_byte;
  rx_stat_t   rx_tag;
  logic [RX_W-1:0] rx_head;

  uart_tq_baud #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_baud (
    .clk_i, .rst_ni, .div_we_i, .div_i, .tick_o(tick)
  );

  uart_tq_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_txq (
    .clk_i, .rst_ni, .push_i(tx_we_i), .din_i(tx_data_i), .pop_i(tx_pop),
    .dout_o(tx_head), .empty_o(tx_empty), .full_o(tx_full_o)
  );

  uart_tq_tx u_tx (
    .clk_i, .rst_ni, .tick_i(tick), .avail_i(!tx_empty), .data_i(tx_head),
    .pop_o(tx_pop), .busy_o(tx_busy), .txd_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxd_s1 <= 1'b1;
      rxd_s2 <= 1'b1;
    end else begin
      rxd_s1 <= rxd_i;
      rxd_s2 <= rxd_s1;
    end
  end

  uart_tq_rx #(.GAP_BITS(GAP_BITS)) u_rx (
    .clk_i, .rst_ni, .tick_i(tick), .rxd_i(rxd_s2), .done_o(rx_done),
    .data_o(rx_byte), .ferr_o(rx_ferr), .brk_o(rx_brk), .gap_o(rx_gap)
  );

  // overrun is carried to the next character that finds room
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ovr_pend <= 1'b0;
    else if (rx_done) ovr_pend <= rx_full;
  end

  always_comb begin
    rx_tag      = '0;
    rx_tag.ferr = rx_ferr;
    rx_tag.ovr  = ovr_pend;
    rx_tag.brk  = rx_brk;
    rx_tag.gap  = rx_gap;
  end

  uart_tq_fifo #(.W(RX_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk_i, .rst_ni, .push_i(rx_done), .din_i({rx_tag, rx_byte}), .pop_i(rx_re_i),
    .dout_o(rx_head), .empty_o(rx_empty_o), .full_o(rx_full)
  );

  assign rx_data_o = rx_head[7:0];
  assign rx_stat_o = rx_head[RX_W-1:8];
  assign tx_dreq_o = !tx_full_o;
  assign rx_dreq_o = !rx_empty_o;
endmodule

// File: rtl/uart_tagq_chk.sv
module uart_tagq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_full_o,
  input logic tx_we_i,
  input logic tx_pop,
  input logic tx_busy,
  input logic txd_o,
  input logic rx_done,
  input logic rx_full,
  input logic ovr_pend,
  input logic rx_brk,
  input logic rx_ferr,
  input logic rx_dreq_o
);
  // R3
  tx_hold_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_full_o && tx_we_i && !tx_pop) |=> tx_full_o);
  // R2
  tx_idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy |-> txd_o);
  // R7
  rx_drop_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && rx_full) |=> ovr_pend);
  // R7
  ovr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && !rx_full) |=> !ovr_pend);
  // R6
  brk_ferr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && rx_brk) |-> rx_ferr);
  // R9
  rx_dreq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_dreq_o) |-> $past(rx_done));
endmodule

bind uart_tagq uart_tagq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_full_o(tx_full_o), .tx_we_i(tx_we_i),
  .tx_pop(tx_pop), .tx_busy(tx_busy), .txd_o(txd_o), .rx_done(rx_done),
  .rx_full(rx_full), .ovr_pend(ovr_pend), .rx_brk(rx_brk), .rx_ferr(rx_ferr),
  .rx_dreq_o(rx_dreq_o)
);

// File: tb/sim_uart_tagq.sv
`timescale 1ns/1ps
module sim_uart_tagq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        div_we_i = 1'b0;
  logic [15:0] div_i = '0;
  logic        tx_we_i = 1'b0;
  logic [7:0]  tx_data_i = '0;
  logic        tx_full_o;
  logic        rx_re_i = 1'b0;
  logic [7:0]  rx_data_o;
  logic [4:0]  rx_stat_o;
  logic        rx_empty_o, tx_dreq_o, rx_dreq_o;
  logic        rxd_i = 1'b1;
  logic        txd_o;

  int n_chk = 0, n_fail = 0;
  int bit_clks = 32;
  int tx_seen = 0;
  bit hold_rd = 1'b0;
  bit first_rx = 1'b1;
  logic [7:0]  tx_q[$];
  string       tx_tag_q[$];
  logic [12:0] rx_q[$];
  string       rx_tag_q[$];

  always #5 clk_i = ~clk_i;

  uart_tagq u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic set_div(input int d);
    @(negedge clk_i);
    div_we_i = 1'b1; div_i = 16'(d);
    @(negedge clk_i);
    div_we_i = 1'b0;
    bit_clks = 16 * (d + 1);
  endtask

  task automatic tx_put(input logic [7:0] b, input bit expect_sent, input string tag);
    @(negedge clk_i);
    tx_we_i = 1'b1; tx_data_i = b;
    if (expect_sent) begin tx_q.push_back(b); tx_tag_q.push_back(tag); end
    @(negedge clk_i);
    tx_we_i = 1'b0;
  endtask

  task automatic rx_frame(input logic [7:0] d, input bit stopb, input int idle_bits,
                          input bit ovr, input bit store, input string tag);
    logic [4:0] st;
    st = {first_rx || (idle_bits >= 4), 1'b0, !stopb && d == 8'h00, ovr, !stopb};
    first_rx = 1'b0;
    @(negedge clk_i);
    rxd_i = 1'b1;
    repeat (idle_bits * bit_clks) @(negedge clk_i);
    rxd_i = 1'b0;
    repeat (bit_clks) @(negedge clk_i);
    for (int i = 0; i < 8; i++) begin
      rxd_i = d[i];
      repeat (bit_clks) @(negedge clk_i);
    end
    rxd_i = stopb;
    if (store) begin rx_q.push_back({st, d}); rx_tag_q.push_back(tag); end
    repeat (bit_clks) @(negedge clk_i);
    rxd_i = 1'b1;
  endtask

  task automatic wait_tx_drain();
    while (tx_q.size() != 0) @(negedge clk_i);
    repeat (3 * bit_clks) @(negedge clk_i);
  endtask

  task automatic wait_rx_drain();
    repeat (bit_clks) @(negedge clk_i);
    while (rx_q.size() != 0) @(negedge clk_i);
  endtask

  // receive scoreboard monitor
  initial begin
    forever begin
      @(negedge clk_i);
      rx_re_i = 1'b0;
      if (rst_ni && !rx_empty_o && !hold_rd) begin
        if (rx_q.size() == 0) begin
          chk(1'b0, "R4 unexpected entry", {19'd0, rx_stat_o, rx_data_o}, 0);
        end else begin
          logic [12:0] e;
          string t;
          e = rx_q.pop_front();
          t = rx_tag_q.pop_front();
          chk({rx_stat_o, rx_data_o} == e, t, {19'd0, rx_stat_o, rx_data_o}, {19'd0, e});
        end
        rx_re_i = 1'b1;
      end
    end
  end

  // transmit line monitor
  initial begin
    forever begin
      @(negedge txd_o);
      begin
        logic [7:0] b;
        logic st0, sp;
        string t;
        repeat (bit_clks / 2) @(negedge clk_i);
        st0 = txd_o;
        for (int i = 0; i < 8; i++) begin
          repeat (bit_clks) @(negedge clk_i);
          b[i] = txd_o;
        end
        repeat (bit_clks) @(negedge clk_i);
        sp = txd_o;
        tx_seen++;
        if (tx_q.size() == 0) begin
          chk(1'b0, "R3 extra frame", {24'd0, b}, 0);
        end else begin
          logic [7:0] e;
          e = tx_q.pop_front();
          t = tx_tag_q.pop_front();
          chk(b == e && !st0 && sp, t, {22'd0, st0, sp, b}, {22'd0, 2'b01, e});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(txd_o == 1'b1, "R1 txd", txd_o, 1);
    chk(rx_empty_o == 1'b1, "R1 rx_empty", rx_empty_o, 1);
    chk(tx_full_o == 1'b0, "R1 tx_full", tx_full_o, 0);
    chk(tx_dreq_o == 1'b1 && rx_dreq_o == 1'b0, "R1 R9 dreq", {tx_dreq_o, rx_dreq_o}, 2'b10);
    rst_ni = 1'b1;
    set_div(1);

    // R2 simple frames
    tx_put(8'hA5, 1'b1, "R2");
    tx_put(8'h01, 1'b1, "R2");
    tx_put(8'h80, 1'b1, "R2");
    wait_tx_drain();

    // R4 R8 receive, gap then back-to-back
    rx_frame(8'h3C, 1'b1, 8, 1'b0, 1'b1, "R8 first");
    rx_frame(8'hC3, 1'b1, 0, 1'b0, 1'b1, "R4 back-to-back");
    rx_frame(8'hFF, 1'b1, 0, 1'b0, 1'b1, "R4");
    rx_frame(8'h5A, 1'b1, 8, 1'b0, 1'b1, "R8 gap");
    // R5 framing, R6 break
    rx_frame(8'h77, 1'b0, 0, 1'b0, 1'b1, "R5");
    rx_frame(8'h00, 1'b0, 8, 1'b0, 1'b1, "R6");
    rx_frame(8'h00, 1'b1, 8, 1'b0, 1'b1, "R4 zero data");
    wait_rx_drain();

    // R3 R9 transmit queue full
    tx_seen = 0;
    @(negedge clk_i);
    for (int i = 0; i < 9; i++) begin
      tx_we_i = 1'b1; tx_data_i = 8'(8'h10 + i);
      tx_q.push_back(8'(8'h10 + i)); tx_tag_q.push_back("R3");
      @(negedge clk_i);
    end
    tx_we_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(tx_full_o == 1'b1, "R3 full", tx_full_o, 1);
    chk(tx_dreq_o == 1'b0, "R9 tx_dreq full", tx_dreq_o, 0);
    tx_put(8'hEE, 1'b0, "R3");
    wait_tx_drain();
    chk(tx_seen == 9, "R3 dropped write", tx_seen, 9);
    chk(tx_dreq_o == 1'b1 && tx_full_o == 1'b0, "R9 tx_dreq", tx_dreq_o, 1);

    // R7 overrun
    hold_rd = 1'b1;
    for (int i = 0; i < 17; i++)
      rx_frame(8'(8'h40 + i), 1'b1, (i == 0) ? 8 : 0, 1'b0, i < 16, "R7 fill");
    repeat (bit_clks) @(negedge clk_i);
    chk(rx_dreq_o == 1'b1 && rx_empty_o == 1'b0, "R9 rx_dreq", rx_dreq_o, 1);
    hold_rd = 1'b0;
    wait_rx_drain();
    repeat (4) @(negedge clk_i);
    chk(rx_dreq_o == 1'b0 && rx_empty_o == 1'b1, "R9 rx_dreq empty", rx_dreq_o, 0);
    rx_frame(8'h99, 1'b1, 8, 1'b1, 1'b1, "R7 overrun flag");
    rx_frame(8'h66, 1'b1, 0, 1'b0, 1'b1, "R7 flag cleared");
    wait_rx_drain();

    // R10 full duplex
    fork
      begin
        tx_put(8'h12, 1'b1, "R10");
        tx_put(8'h34, 1'b1, "R10");
        tx_put(8'h56, 1'b1, "R10");
      end
      begin
        rx_frame(8'hAB, 1'b1, 8, 1'b0, 1'b1, "R10");
        rx_frame(8'hCD, 1'b1, 0, 1'b0, 1'b1, "R10");
      end
    join
    wait_tx_drain();
    wait_rx_drain();

    // R11 new divisor
    set_div(3);
    tx_put(8'h69, 1'b1, "R11");
    rx_frame(8'h96, 1'b1, 8, 1'b0, 1'b1, "R11");
    wait_tx_drain();
    wait_rx_drain();

    chk(tx_q.size() == 0 && rx_q.size() == 0, "R2 R4 queues drained",
        tx_q.size() + rx_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule